// File: doc/BRIEF.md
# Word Block Transfer and Compare Engine

The engine moves a run of 16-bit words between a local word memory and an external bus, in either direction. It can also compare a block in local memory against the same block on the bus. One start pulse hands it a subopcode, a local base address, a bus page, a 16-bit bus low address and a word count. The sequencer then runs the whole block without further help.

Word modes issue one 16-bit bus cycle per word. Byte modes split each word into two 8-bit bus cycles, either high byte first or low byte first. Compare mode walks the block from its last word toward its first and stops at the first word that differs. It then reports a one-based offset for that word, or zero when the whole block matched.

The local memory port has separate read and write strobes, and read data arrives one cycle after the read strobe. The bus side uses a request/acknowledge handshake with a responder.

Top module: `blkmove`

## Requirements
- R1: Subopcode 0 writes words to the bus and subopcode 4 reads words from the bus. Each uses one word cycle (`busByte`=0) per word k, at bus low address base+k, with word k taken from or stored to local address localBase+k.
- R2: Subopcodes 1, 2, 5, 6, 21 and 22 use byte cycles (`busByte`=1). Word k uses bus low address base+2k and then base+2k+1. The byte travels on bits 7:0 of the bus data and bits 15:8 are driven to zero.
- R3: In straight order (subopcodes 1, 5, 21) the high byte of a word sits at the even bus address and the low byte at the odd one. Swapped order (subopcodes 2, 6, 22) reverses this, for writing, reading and comparing alike.
- R4: Bus-to-local subopcodes (4, 5, 6) write each assembled word to local address localBase+k, in ascending k.
- R5: The bus low address wraps modulo 2^16, and `busPageOut` keeps the page given at start for the whole block.
- R6: A word count of zero with a legal subopcode performs no bus or memory cycle. It pulses `done` with `zeroCount`=1, `illegalOp`=0 and `result`=0.
- R7: Subopcodes 20, 21 and 22 compare bus words with local words, starting at word count-1 and moving toward word 0. The scan stops at the first mismatch and sets `result` to k+1 for the failing word k. If every word matches, `result` is 0.
- R8: Any other subopcode (for example 3, 7 or 23) performs no bus or memory cycle. It pulses `done` with `illegalOp`=1 and `zeroCount`=0. An illegal subopcode takes precedence over a zero count.
- R9: After reset the engine is idle, with `done`, `busReq`, the flags and `result` all at 0. `done` is a single-cycle pulse at the end of every operation. `result` and both flags keep their values until the next accepted start, and transfer subopcodes leave `result` at 0.
- R10: While `busReq` is high and `busAck` is low, the bus address, page, write data, direction and width all hold stable. No bus or memory strobe is active in the cycle `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts an operation when the engine is idle |
| subOp | input | 5 | Subopcode selecting direction and byte format |
| localBase | input | LA_W | Local word address of word 0 |
| busPage | input | PAGE_W | Bus page held for the block |
| busAddr | input | ADDR_W | Bus low address of word 0 |
| wordCount | input | CNT_W | Number of words |
| memAddr | output | LA_W | Local memory address |
| memRd | output | 1 | Local read strobe; data valid the next cycle |
| memWr | output | 1 | Local write strobe |
| memWdata | output | WORD_W | Local write data |
| memRdata | input | WORD_W | Local read data |
| busReq | output | 1 | Bus cycle request, held until acknowledged |
| busWe | output | 1 | 1 for a bus write, 0 for a read |
| busByte | output | 1 | 1 for a byte cycle, 0 for a word cycle |
| busPageOut | output | PAGE_W | Bus page |
| busAddrOut | output | ADDR_W | Bus low address |
| busWdata | output | WORD_W | Bus write data |
| busAck | input | 1 | Bus cycle complete; read data valid with it |
| busRdata | input | WORD_W | Bus read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| illegalOp | output | 1 | Last start had an unimplemented subopcode |
| zeroCount | output | 1 | Last start had a zero word count |
| result | output | CNT_W | Compare result: failing offset plus one, or 0 |

## Verification
The embedded assertions check handshake stability on every cycle, the single-cycle length of `done`, and the absence of bus or memory strobes while `done` is high. They also check that no bus request appears while an error flag is up. Byte order, address stepping across the 16-bit wrap, and local write data are observable only through the scoreboard. It predicts each bus write, memory write and end-of-operation record from its own models of both memories. The backward direction of the compare scan is shown only by scenarios with several mismatching words, where the reported offset must name the highest one.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;
  localparam int OP_W = 5;

  typedef enum logic [1:0] {
    DIR_OUT = 2'd0,
    DIR_IN  = 2'd1,
    DIR_CHK = 2'd2
  } dir_e;

  // Strobes from sequencer to datapath
  typedef struct packed {
    logic load;
    logic idxFirst;
    logic idxLast;
    logic idxInc;
    logic idxDec;
    logic byteClr;
    logic byteSet;
    logic capLocal;
    logic capBus;
    logic resClr;
    logic resMiss;
    logic byteMode;
    logic swapOrder;
  } strobe_t;

  // Legal: low two bits not 3, bit 3 clear, compare family needs bit 2
  function automatic logic opLegal(input logic [OP_W-1:0] op);
    return (op[1:0] != 2'b11) && !op[3] && (!op[4] || op[2]);
  endfunction

  function automatic dir_e opDir(input logic [OP_W-1:0] op);
    if (op[4]) return DIR_CHK;
    if (op[2]) return DIR_IN;
    return DIR_OUT;
  endfunction
endpackage

// File: rtl/blkmove_ctrl.sv
module blkmove_ctrl
  import blkmove_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [OP_W-1:0] subOp,
  input  logic            cntIsZero,
  input  logic            busAck,
  input  logic            lastIdx,
  input  logic            firstIdx,
  input  logic            mismatch,
  output strobe_t         stb,
  output logic            busReq,
  output logic            busWe,
  output logic            memRd,
  output logic            memWr,
  output logic            busy,
  output logic            done,
  output logic            illegalOp,
  output logic            zeroCount
);
  typedef enum logic [2:0] {
    S_IDLE, S_MRD, S_MCAP, S_BUS0, S_BUS1, S_MWR, S_CMP, S_NEXT
  } state_e;

  state_e state, nextState, afterBus;
  logic   doneQ;
  dir_e   dirQ;
  logic   byteModeQ, swapQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      doneQ     <= 1'b0;
      dirQ      <= DIR_OUT;
      byteModeQ <= 1'b0;
      swapQ     <= 1'b0;
      illegalOp <= 1'b0;
      zeroCount <= 1'b0;
    end else begin
      state <= nextState;
      doneQ <= endNow;
      if (state == S_IDLE && start) begin
        dirQ      <= opDir(subOp);
        byteModeQ <= (subOp[1:0] != 2'b00);
        swapQ     <= subOp[1];
        illegalOp <= !opLegal(subOp);
        zeroCount <= opLegal(subOp) && cntIsZero;
      end
    end
  end

  logic endNow;

  always_comb begin
    afterBus = (dirQ == DIR_IN) ? S_MWR : ((dirQ == DIR_CHK) ? S_CMP : S_NEXT);
    nextState     = state;
    endNow        = 1'b0;
    stb           = '0;
    stb.byteMode  = byteModeQ;
    stb.swapOrder = swapQ;
    busReq        = 1'b0;
    memRd         = 1'b0;
    memWr         = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        stb.load    = 1'b1;
        stb.resClr  = 1'b1;
        stb.byteClr = 1'b1;
        if (!opLegal(subOp) || cntIsZero) begin
          endNow = 1'b1;
        end else if (opDir(subOp) == DIR_CHK) begin
          stb.idxLast = 1'b1;
          nextState   = S_MRD;
        end else begin
          stb.idxFirst = 1'b1;
          nextState    = (opDir(subOp) == DIR_IN) ? S_BUS0 : S_MRD;
        end
      end
      S_MRD: begin
        memRd     = 1'b1;
        nextState = S_MCAP;
      end
      S_MCAP: begin
        stb.capLocal = 1'b1;
        nextState    = S_BUS0;
      end
      S_BUS0: begin
        busReq = 1'b1;
        if (busAck) begin
          stb.capBus = (dirQ != DIR_OUT);
          if (byteModeQ) begin
            stb.byteSet = 1'b1;
            nextState   = S_BUS1;
          end else begin
            nextState = afterBus;
          end
        end
      end
      S_BUS1: begin
        busReq = 1'b1;
        if (busAck) begin
          stb.capBus = (dirQ != DIR_OUT);
          nextState  = afterBus;
        end
      end
      S_MWR: begin
        memWr     = 1'b1;
        nextState = S_NEXT;
      end
      S_CMP: begin
        if (mismatch) begin
          stb.resMiss = 1'b1;
          endNow      = 1'b1;
          nextState   = S_IDLE;
        end else if (firstIdx) begin
          endNow    = 1'b1;
          nextState = S_IDLE;
        end else begin
          stb.idxDec  = 1'b1;
          stb.byteClr = 1'b1;
          nextState   = S_MRD;
        end
      end
      S_NEXT: begin
        if (lastIdx) begin
          endNow    = 1'b1;
          nextState = S_IDLE;
        end else begin
          stb.idxInc  = 1'b1;
          stb.byteClr = 1'b1;
          nextState   = (dirQ == DIR_IN) ? S_BUS0 : S_MRD;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busWe = (dirQ == DIR_OUT);
  assign busy  = (state != S_IDLE);
  assign done  = doneQ;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/blkmove_dpath.sv
module blkmove_dpath
  import blkmove_pkg::*;
#(
  parameter int LA_W   = 8,
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 4,
  parameter int ADDR_W = 16,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [LA_W-1:0]   localBase,
  input  logic [PAGE_W-1:0] busPage,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  wordCount,
  input  logic [WORD_W-1:0] memRdata,
  input  logic [WORD_W-1:0] busRdata,
  output logic [LA_W-1:0]   memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [PAGE_W-1:0] busPageOut,
  output logic [ADDR_W-1:0] busAddrOut,
  output logic [WORD_W-1:0] busWdata,
  output logic [CNT_W-1:0]  result,
  output logic              lastIdx,
  output logic              firstIdx,
  output logic              mismatch
);
  localparam int HALF = WORD_W / 2;

  logic [LA_W-1:0]   baseQ;
  logic [PAGE_W-1:0] pageQ;
  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  cntQ, idx, resultQ;
  logic              byteSel;
  logic [WORD_W-1:0] localWord, busWord;
  logic              highSlot;
  logic [ADDR_W-1:0] wordOff, byteOff;

  // Even address holds the high byte unless the order is swapped
  assign highSlot = !(byteSel ^ stb.swapOrder);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ     <= '0;
      pageQ     <= '0;
      addrQ     <= '0;
      cntQ      <= '0;
      idx       <= '0;
      byteSel   <= 1'b0;
      localWord <= '0;
      busWord   <= '0;
      resultQ   <= '0;
    end else begin
      if (stb.load) begin
        baseQ <= localBase;
        pageQ <= busPage;
        addrQ <= busAddr;
        cntQ  <= wordCount;
      end
      if (stb.idxFirst)     idx <= '0;
      else if (stb.idxLast) idx <= wordCount - CNT_W'(1);
      else if (stb.idxInc)  idx <= idx + CNT_W'(1);
      else if (stb.idxDec)  idx <= idx - CNT_W'(1);
      if (stb.byteClr)      byteSel <= 1'b0;
      else if (stb.byteSet) byteSel <= 1'b1;
      if (stb.capLocal) localWord <= memRdata;
      if (stb.capBus) begin
        if (!stb.byteMode) busWord <= busRdata;
        else if (highSlot) busWord[WORD_W-1:HALF] <= busRdata[HALF-1:0];
        else               busWord[HALF-1:0]      <= busRdata[HALF-1:0];
      end
      if (stb.resClr)       resultQ <= '0;
      else if (stb.resMiss) resultQ <= idx + CNT_W'(1);
    end
  end

  assign wordOff    = ADDR_W'(idx);
  assign byteOff    = ADDR_W'({idx, byteSel});
  assign busAddrOut = addrQ + (stb.byteMode ? byteOff : wordOff);
  assign busPageOut = pageQ;
  assign busWdata   = !stb.byteMode ? localWord :
                      {{HALF{1'b0}}, highSlot ? localWord[WORD_W-1:HALF] : localWord[HALF-1:0]};
  assign memAddr    = baseQ + LA_W'(idx);
  assign memWdata   = busWord;
  assign result     = resultQ;
  assign lastIdx    = (idx == cntQ - CNT_W'(1));
  assign firstIdx   = (idx == '0);
  assign mismatch   = (busWord != localWord);
endmodule

// File: rtl/blkmove.sv
module blkmove
  import blkmove_pkg::*;
#(
  parameter int LA_W   = 8,
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 4,
  parameter int ADDR_W = 16,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [OP_W-1:0]   subOp,
  input  logic [LA_W-1:0]   localBase,
  input  logic [PAGE_W-1:0] busPage,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  wordCount,
  output logic [LA_W-1:0]   memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  output logic              busReq,
  output logic              busWe,
  output logic              busByte,
  output logic [PAGE_W-1:0] busPageOut,
  output logic [ADDR_W-1:0] busAddrOut,
  output logic [WORD_W-1:0] busWdata,
  input  logic              busAck,
  input  logic [WORD_W-1:0] busRdata,
  output logic              busy,
  output logic              done,
  output logic              illegalOp,
  output logic              zeroCount,
  output logic [CNT_W-1:0]  result
);
  strobe_t stb;
  logic    lastIdx, firstIdx, mismatch;

  blkmove_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .subOp(subOp),
    .cntIsZero(wordCount == '0), .busAck(busAck),
    .lastIdx(lastIdx), .firstIdx(firstIdx), .mismatch(mismatch),
    .stb(stb), .busReq(busReq), .busWe(busWe), .memRd(memRd), .memWr(memWr),
    .busy(busy), .done(done), .illegalOp(illegalOp), .zeroCount(zeroCount)
  );

  blkmove_dpath #(
    .LA_W(LA_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .localBase(localBase), .busPage(busPage), .busAddr(busAddr), .wordCount(wordCount),
    .memRdata(memRdata), .busRdata(busRdata),
    .memAddr(memAddr), .memWdata(memWdata), .busPageOut(busPageOut),
    .busAddrOut(busAddrOut), .busWdata(busWdata), .result(result),
    .lastIdx(lastIdx), .firstIdx(firstIdx), .mismatch(mismatch)
  );

  assign busByte = stb.byteMode;

  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busAddrOut) && $stable(busPageOut)
                          && $stable(busWdata) && $stable(busWe) && $stable(busByte));

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busReq && !memRd && !memWr);

  // R6 R8
  err_no_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> !illegalOp && !zeroCount);

  // R5
  page_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && $past(busReq) |-> $stable(busPageOut));
endmodule

// File: tb/test_blkmove.sv
module test_blkmove;
  localparam int CLK_PERIOD = 10;
  localparam int LA_W = 8, CNT_W = 16, PAGE_W = 4, ADDR_W = 16, WORD_W = 16;
  localparam int LSZ = 1 << LA_W;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [4:0] subOp = '0;
  logic [LA_W-1:0] localBase = '0;
  logic [PAGE_W-1:0] busPage = '0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [CNT_W-1:0] wordCount = '0;
  logic [LA_W-1:0] memAddr;
  logic memRd, memWr, busReq, busWe, busByte, busy, done, illegalOp, zeroCount;
  logic [WORD_W-1:0] memWdata, busWdata;
  logic [WORD_W-1:0] memRdata = '0, busRdata = '0;
  logic busAck = 1'b0;
  logic [PAGE_W-1:0] busPageOut;
  logic [ADDR_W-1:0] busAddrOut;
  logic [CNT_W-1:0] result;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkmove #(.LA_W(LA_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W))
  i_blkmove (
    .clk(clk), .rstN(rstN), .start(start), .subOp(subOp), .localBase(localBase),
    .busPage(busPage), .busAddr(busAddr), .wordCount(wordCount),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr), .memWdata(memWdata), .memRdata(memRdata),
    .busReq(busReq), .busWe(busWe), .busByte(busByte), .busPageOut(busPageOut),
    .busAddrOut(busAddrOut), .busWdata(busWdata), .busAck(busAck), .busRdata(busRdata),
    .busy(busy), .done(done), .illegalOp(illegalOp), .zeroCount(zeroCount), .result(result)
  );

  // Scoreboard kinds: 0 bus word write, 1 bus byte write, 2 local write, 3 end record
  typedef struct { int kind; int addr; int data; string tag; } ev_t;
  ev_t expQ[$];
  int checks = 0, failures = 0, activity = 0, latency = 0, waitCnt = 0;

  logic [15:0] lmem [LSZ];
  logic [7:0]  bbmem [65536];
  logic [15:0] bwmem [65536];

  task automatic pushEv(input int kind, input int addr, input int data, input string tag);
    ev_t e;
    e.kind = kind; e.addr = addr; e.data = data; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic popCheck(input int kind, input int addr, input int data);
    ev_t e;
    checks++;
    if (expQ.size() == 0) begin
      failures++;
      $display("FAIL R6/R8 unexpected event: kind %0d addr %h data %h, expected none", kind, addr, data);
    end else begin
      e = expQ.pop_front();
      if (e.kind != kind || e.addr != addr || e.data != data) begin
        failures++;
        $display("FAIL %s: kind %0d addr %h data %h, expected kind %0d addr %h data %h",
                 e.tag, kind, addr, data, e.kind, e.addr, e.data);
      end
    end
  endtask

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
  endtask

  // Local memory model, one-cycle read latency; writes go to the scoreboard
  initial forever begin
    @(negedge clk);
    if (busReq || memRd || memWr) activity++;
    if (memRd) memRdata = lmem[memAddr];
    if (memWr) begin
      lmem[memAddr] = memWdata;
      popCheck(2, int'(memAddr), int'(memWdata));
    end
  end

  // Bus responder with programmable wait states
  initial forever begin
    @(negedge clk);
    if (busAck) busAck = 1'b0;
    else if (busReq) begin
      if (waitCnt >= latency) begin
        waitCnt = 0;
        if (busWe) begin
          if (busByte) bbmem[busAddrOut] = busWdata[7:0];
          else         bwmem[busAddrOut] = busWdata;
          popCheck(busByte ? 1 : 0, int'({busPageOut, busAddrOut}), int'(busWdata));
        end else begin
          busRdata = busByte ? {8'h00, bbmem[busAddrOut]} : bwmem[busAddrOut];
        end
        busAck = 1'b1;
      end else waitCnt++;
    end
  end

  // End-of-operation monitor
  initial forever begin
    @(negedge clk);
    if (done) popCheck(3, int'({illegalOp, zeroCount}), int'(result));
  end

  function automatic logic [15:0] busWordAt(input int fmt, input int ba, input int k);
    logic [7:0] ev, od;
    if (fmt == 0) return bwmem[(ba + k) & 16'hFFFF];
    ev = bbmem[(ba + 2*k) & 16'hFFFF];
    od = bbmem[(ba + 2*k + 1) & 16'hFFFF];
    return (fmt == 1) ? {ev, od} : {od, ev};
  endfunction

  task automatic runOp(input int op, input int lb, input int pg, input int ba,
                       input int cnt, input int lat, input string tag);
    logic legal;
    int dir, fmt, res;
    logic [15:0] w;
    bit seen;
    legal = op inside {0, 1, 2, 4, 5, 6, 20, 21, 22};
    dir = (op >= 20) ? 2 : ((op >= 4) ? 1 : 0);
    fmt = op % 4;
    res = 0;
    if (legal && cnt > 0) begin
      for (int k = 0; k < cnt; k++) begin
        if (dir == 0) begin
          w = lmem[(lb + k) % LSZ];
          if (fmt == 0) pushEv(0, pg * 65536 + ((ba + k) & 16'hFFFF), int'(w), tag);
          else begin
            pushEv(1, pg * 65536 + ((ba + 2*k) & 16'hFFFF), int'(fmt == 1 ? w[15:8] : w[7:0]), tag);
            pushEv(1, pg * 65536 + ((ba + 2*k + 1) & 16'hFFFF), int'(fmt == 1 ? w[7:0] : w[15:8]), tag);
          end
        end else if (dir == 1) begin
          pushEv(2, (lb + k) % LSZ, int'(busWordAt(fmt, ba, k)), tag);
        end
      end
      if (dir == 2) begin
        for (int k = cnt - 1; k >= 0; k--) begin
          if (busWordAt(fmt, ba, k) != lmem[(lb + k) % LSZ]) begin
            res = k + 1;
            break;
          end
        end
      end
    end
    pushEv(3, (!legal) ? 2 : ((cnt == 0) ? 1 : 0), res, tag);
    latency = lat;
    activity = 0;
    @(negedge clk);
    start = 1'b1; subOp = 5'(op); localBase = LA_W'(lb); busPage = PAGE_W'(pg);
    busAddr = ADDR_W'(ba); wordCount = CNT_W'(cnt);
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    for (int i = 0; i < 5000; i++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    check(seen, tag, int'(seen), 1);
    repeat (3) @(negedge clk);
    // R9: result and flags hold after done, done low again
    check(expQ.size() == 0, tag, expQ.size(), 0);
    check(!done && result == CNT_W'(res), "R9", int'(result), res);
    if (!legal || cnt == 0) check(activity == 0, tag, activity, 0);
    expQ.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R9 watchdog: operation never completed, actual timeout expected done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < LSZ; i++) lmem[i] = 16'(16'hA000 + i * 37);
    for (int i = 0; i < 65536; i++) begin
      bbmem[i] = 8'(i * 7 + 3);
      bwmem[i] = 16'(i * 13 + 5);
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !busReq && !memRd && !memWr && result == '0
          && !illegalOp && !zeroCount, "R9 reset", int'(busy), 0);

    runOp(0, 8'h10, 5, 16'h0100, 3, 0, "R1 out words");
    runOp(1, 8'h20, 3, 16'h0200, 3, 1, "R2 R3 out straight bytes");
    runOp(2, 8'h20, 3, 16'h0240, 2, 2, "R3 out swapped bytes");
    runOp(4, 8'h80, 6, 16'h0500, 4, 0, "R4 in words");
    runOp(5, 8'h90, 2, 16'h0700, 3, 1, "R4 R3 in straight bytes");
    runOp(6, 8'hA0, 2, 16'h0800, 3, 0, "R4 R3 in swapped bytes");
    runOp(1, 8'hF0, 9, 16'hFFFE, 2, 0, "R5 byte wrap");
    runOp(4, 8'hFE, 1, 16'hFFFF, 3, 1, "R5 word wrap");
    runOp(1, 8'h00, 1, 16'h0000, 0, 0, "R6 zero count");
    runOp(3, 8'h00, 1, 16'h0000, 2, 0, "R8 op3");
    runOp(7, 8'h00, 1, 16'h0000, 2, 0, "R8 op7");
    runOp(23, 8'h00, 1, 16'h0000, 0, 0, "R8 op23 beats zero");

    // R7 compares against blocks just copied in
    runOp(20, 8'h80, 6, 16'h0500, 4, 0, "R7 words match");
    runOp(5, 8'h40, 4, 16'h0300, 5, 0, "R7 setup");
    runOp(21, 8'h40, 4, 16'h0300, 5, 1, "R7 bytes match");
    bbmem[16'h0302] = ~bbmem[16'h0302];
    bbmem[16'h0307] = ~bbmem[16'h0307];
    runOp(21, 8'h40, 4, 16'h0300, 5, 0, "R7 backward first miss");
    bbmem[16'h0307] = ~bbmem[16'h0307];
    runOp(21, 8'h40, 4, 16'h0300, 5, 0, "R7 single miss");
    runOp(6, 8'h60, 7, 16'h0400, 4, 0, "R7 setup swapped");
    bbmem[16'h0400] = ~bbmem[16'h0400];
    runOp(22, 8'h60, 7, 16'h0400, 4, 2, "R7 swapped miss word0");

    summary();
    $finish;
  end
endmodule